// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the 8-bit status word of a small CPU core. The word holds six flags: interrupt enable, zero, a two-bit register bank select, auxiliary carry, in-service priority and carry. One bit of the word is a constant zero. The instruction decoder drives single-cycle strobes into the block. The strobes cover enabling and disabling interrupts, interrupt acknowledge, write enables for the ALU result flags and the priority flag, and a bank change. The register applies them on the next rising clock edge.

For saving and restoring the word, the block only presents and accepts data; it contains no stack memory. On an interrupt acknowledge or a push-status command, it offers the word as it stands before that cycle's update, together with a valid flag. On any return or pop-status command, it loads the word from the stack data input, and this load overrides every other strobe in the same cycle. The core reads the whole word, the selected bank and the interrupt enable flag as separate outputs.

Top module: `psw_flag_reg`

## Requirements
- R1: After a synchronous active-low reset, the word reads 8'h02: only the in-service priority flag (bit 1) is set.
- R2: The bit positions are fixed as: bit 7 interrupt enable, bit 6 zero, bit 5 bank high, bit 4 auxiliary carry, bit 3 bank low, bit 2 constant 0, bit 1 in-service priority, bit 0 carry. `bank` equals {bit 5, bit 3} and `int_en` equals bit 7.
- R3: Interrupt enable reads 0 one cycle after `di_cmd` or `irq_ack`, including when `ei_cmd` is high in the same cycle.
- R4: Interrupt enable reads 1 one cycle after `ei_cmd` when neither `di_cmd` nor `irq_ack` is high.
- R5: When `z_we` is high, the zero flag takes `z_in` on the next cycle. A value of 1 means the result was zero.
- R6: When `ac_we`, `cy_we` or `isp_we` is high, the auxiliary carry, carry or in-service priority flag takes `ac_in`, `cy_in` or `isp_in` on the next cycle.
- R7: When `bank_we` is high, {bit 5, bit 3} takes `bank_in` on the next cycle.
- R8: `push_valid` is high in exactly the cycles where `irq_ack` or `push_cmd` is high. In those cycles `push_data` equals the word before that cycle's update.
- R9: When `pop_cmd` is high, the next word equals `pop_data` with bit 2 forced to 0, whatever other strobes are high in that cycle.
- R10: In a cycle with no strobe high, the word keeps its value.

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ei_cmd | input | 1 | Enable-interrupts strobe |
| di_cmd | input | 1 | Disable-interrupts strobe |
| irq_ack | input | 1 | Interrupt acknowledge strobe |
| z_we | input | 1 | Zero flag write enable |
| z_in | input | 1 | Zero flag value (1 = result zero) |
| ac_we | input | 1 | Auxiliary carry write enable |
| ac_in | input | 1 | Auxiliary carry value |
| cy_we | input | 1 | Carry write enable |
| cy_in | input | 1 | Carry value |
| isp_we | input | 1 | In-service priority write enable |
| isp_in | input | 1 | In-service priority value |
| bank_we | input | 1 | Bank select write enable |
| bank_in | input | 2 | New bank number |
| push_cmd | input | 1 | Push-status strobe |
| pop_cmd | input | 1 | Restore strobe (return or pop-status) |
| pop_data | input | 8 | Word read back from the stack |
| push_valid | output | 1 | Word offered for saving this cycle |
| push_data | output | 8 | Word to save |
| psw | output | 8 | Full status word |
| bank | output | 2 | Selected register bank |
| int_en | output | 1 | Interrupt enable flag |

## Verification
The assertions assume that every strobe is a known 0 or 1 at each clock edge. They also assume that the decoder may raise any mix of strobes in one cycle, with the fixed priorities above deciding the result. The stimulus therefore drives only known levels. It walks all 256 `pop_data` values, sweeps every combination of the interrupt strobes, and then runs a long pseudo-random stream that includes colliding strobes, such as a pop together with flag writes, or an enable together with an acknowledge. A reference word computed in the bench from the requirements is compared every cycle.

// File: rtl/psw_pkg.sv
// psw_pkg: bit positions, reset word and the word type shared by the
// status flag register modules. The positions are fixed by software.
package psw_pkg;
    localparam int WORD_W  = 8;
    localparam int BANK_W  = 2;
    localparam int B_IE    = 7;
    localparam int B_Z     = 6;
    localparam int B_RB1   = 5;
    localparam int B_AC    = 4;
    localparam int B_RB0   = 3;
    localparam int B_ZERO  = 2;
    localparam int B_ISP   = 1;
    localparam int B_CY    = 0;
    typedef logic [WORD_W-1:0] psw_word_t;
    localparam psw_word_t RESET_WORD = psw_word_t'(8'h02);
    // Mask that clears the constant-zero bit.
    localparam psw_word_t KEEP_MASK  = ~(psw_word_t'(1) << B_ZERO);
endpackage

// File: rtl/psw_next_logic.sv
// psw_next_logic: combinational next-word computation.
// Assumes strobes are single-cycle decoder outputs; restore from stack
// beats everything, interrupt-enable clear beats set.
module psw_next_logic
    import psw_pkg::*;
(
    input  psw_word_t              cur,
    input  logic                   ei_cmd,
    input  logic                   di_cmd,
    input  logic                   irq_ack,
    input  logic                   z_we,
    input  logic                   z_in,
    input  logic                   ac_we,
    input  logic                   ac_in,
    input  logic                   cy_we,
    input  logic                   cy_in,
    input  logic                   isp_we,
    input  logic                   isp_in,
    input  logic                   bank_we,
    input  logic [BANK_W-1:0]      bank_in,
    input  logic                   pop_cmd,
    input  psw_word_t              pop_data,
    output psw_word_t              nxt
);
    // Purpose: merge all flag updates with fixed priority.
    always_comb begin
        nxt = cur;
        if (di_cmd || irq_ack) nxt[B_IE] = 1'b0;
        else if (ei_cmd)       nxt[B_IE] = 1'b1;
        if (z_we)   nxt[B_Z]   = z_in;
        if (ac_we)  nxt[B_AC]  = ac_in;
        if (cy_we)  nxt[B_CY]  = cy_in;
        if (isp_we) nxt[B_ISP] = isp_in;
        if (bank_we) begin
            nxt[B_RB1] = bank_in[1];
            nxt[B_RB0] = bank_in[0];
        end
        if (pop_cmd) nxt = pop_data;
        nxt = nxt & KEEP_MASK;
    end
endmodule

// File: rtl/psw_push_port.sv
// psw_push_port: presents the pre-update word for saving to the stack.
// Assumes the caller captures push_data in the same cycle push_valid is high.
module psw_push_port
    import psw_pkg::*;
(
    input  psw_word_t cur,
    input  logic      irq_ack,
    input  logic      push_cmd,
    output logic      push_valid,
    output psw_word_t push_data
);
    // Purpose: offer the current register value on ack or push.
    always_comb begin
        push_valid = irq_ack | push_cmd;
        push_data  = cur;
    end
endmodule

// File: rtl/psw_flag_reg.sv
// psw_flag_reg: top of the status flag register. Holds the word, decodes
// bank and interrupt-enable views, exposes push data, accepts pop data.
// Assumes synchronous active-low reset and known-valued strobes.
module psw_flag_reg
    import psw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ei_cmd,
    input  logic        di_cmd,
    input  logic        irq_ack,
    input  logic        z_we,
    input  logic        z_in,
    input  logic        ac_we,
    input  logic        ac_in,
    input  logic        cy_we,
    input  logic        cy_in,
    input  logic        isp_we,
    input  logic        isp_in,
    input  logic        bank_we,
    input  logic [1:0]  bank_in,
    input  logic        push_cmd,
    input  logic        pop_cmd,
    input  logic [7:0]  pop_data,
    output logic        push_valid,
    output logic [7:0]  push_data,
    output logic [7:0]  psw,
    output logic [1:0]  bank,
    output logic        int_en
);
    psw_word_t word_q;
    psw_word_t word_d;

    psw_next_logic u_next (
        .cur(word_q), .ei_cmd(ei_cmd), .di_cmd(di_cmd), .irq_ack(irq_ack),
        .z_we(z_we), .z_in(z_in), .ac_we(ac_we), .ac_in(ac_in),
        .cy_we(cy_we), .cy_in(cy_in), .isp_we(isp_we), .isp_in(isp_in),
        .bank_we(bank_we), .bank_in(bank_in), .pop_cmd(pop_cmd),
        .pop_data(pop_data), .nxt(word_d)
    );

    psw_push_port u_push (
        .cur(word_q), .irq_ack(irq_ack), .push_cmd(push_cmd),
        .push_valid(push_valid), .push_data(push_data)
    );

    // Purpose: hold the status word; reset loads the fixed reset word.
    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= RESET_WORD;
        else        word_q <= word_d;
    end

    // Purpose: drive the word and its decoded views.
    always_comb begin
        psw    = word_q;
        bank   = {word_q[B_RB1], word_q[B_RB0]};
        int_en = word_q[B_IE];
    end

    p_reset_word_r1: assert property (@(posedge clk)
        !rst_n |=> psw == RESET_WORD);
    p_zero_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        psw[B_ZERO] == 1'b0);
    p_ie_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_cmd && (di_cmd || irq_ack)) |=> !int_en);
    p_ie_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_cmd && ei_cmd && !di_cmd && !irq_ack) |=> int_en);
    p_bank_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_cmd && bank_we) |=> bank == $past(bank_in));
    p_pop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_cmd |=> psw == ($past(pop_data) & KEEP_MASK));
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ei_cmd || di_cmd || irq_ack || z_we || ac_we || cy_we || isp_we ||
          bank_we || pop_cmd) |=> $stable(psw));
endmodule

// File: tb/psw_flag_reg_test.sv
`timescale 1ns/1ps
module psw_flag_reg_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ei_cmd = 0, di_cmd = 0, irq_ack = 0, z_we = 0, z_in = 0;
    logic ac_we = 0, ac_in = 0, cy_we = 0, cy_in = 0, isp_we = 0, isp_in = 0;
    logic bank_we = 0, push_cmd = 0, pop_cmd = 0;
    logic [1:0] bank_in = 0;
    logic [7:0] pop_data = 0;
    logic push_valid, int_en;
    logic [7:0] push_data, psw;
    logic [1:0] bank;
    int n_cmp = 0, n_bad = 0;
    logic [7:0] model;
    logic [31:0] lfsr = 32'h1ACE_B00C;
    bit done = 0;

    always #2.5 clk = ~clk;

    psw_flag_reg uut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Reference next word written from the requirements (R3..R9).
    function automatic logic [7:0] ref_next(input logic [7:0] w);
        logic [7:0] n = w;
        if (di_cmd || irq_ack) n[7] = 0; else if (ei_cmd) n[7] = 1;
        if (z_we) n[6] = z_in;
        if (ac_we) n[4] = ac_in;
        if (cy_we) n[0] = cy_in;
        if (isp_we) n[1] = isp_in;
        if (bank_we) begin n[5] = bank_in[1]; n[3] = bank_in[0]; end
        if (pop_cmd) n = pop_data;
        n[2] = 0;
        return n;
    endfunction

    // Inputs are set after a falling edge; checks run before the next one.
    task automatic step(input string req);
        #0.5;
        chk("R8 push_valid", {7'd0, push_valid}, {7'd0, irq_ack | push_cmd});
        if (irq_ack | push_cmd) chk("R8 push_data", push_data, model);
        model = ref_next(model);
        @(posedge clk); @(negedge clk);
        chk(req, psw, model);
        chk("R2 bank", {6'd0, bank}, {6'd0, model[5], model[3]});
        chk("R2 int_en", {7'd0, int_en}, {7'd0, model[7]});
    endtask

    task automatic idle();
        {ei_cmd, di_cmd, irq_ack, z_we, ac_we, cy_we, isp_we, bank_we, push_cmd, pop_cmd} = '0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset word", psw, 8'h02);
        rst_n = 1;
        model = 8'h02;
        idle(); step("R10 idle hold");
        // R9/R2: every restore value, bit 2 forced low
        for (int v = 0; v < 256; v++) begin
            idle(); pop_cmd = 1; pop_data = 8'(v); step("R9 pop all values");
        end
        // R9: pop overrides everything
        idle(); {ei_cmd, z_we, z_in, ac_we, ac_in, cy_we, cy_in, isp_we, isp_in, bank_we} = '1;
        bank_in = 2'b11; pop_cmd = 1; pop_data = 8'h04; step("R9 pop priority");
        // R3/R4: all combinations of interrupt strobes from both IE states
        for (int s = 0; s < 2; s++)
            for (int c = 0; c < 8; c++) begin
                idle(); ei_cmd = ~s[0]; di_cmd = s[0]; step("R4/R3 prime");
                idle(); {ei_cmd, di_cmd, irq_ack} = 3'(c); step("R3 R4 ie combos");
            end
        // R7: every bank value
        for (int b = 0; b < 4; b++) begin
            idle(); bank_we = 1; bank_in = 2'(b); step("R7 bank load");
        end
        // R5/R6/R8/R10: pseudo-random mixed strobes
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            idle();
            {ei_cmd, di_cmd, irq_ack, z_we, z_in, ac_we, ac_in, cy_we} = lfsr[7:0] & lfsr[15:8] & lfsr[23:16];
            {cy_in, isp_we, isp_in, bank_we} = lfsr[19:16];
            bank_in = lfsr[25:24];
            push_cmd = lfsr[26];
            pop_cmd = (lfsr[31:28] == 4'hF);
            pop_data = lfsr[31:24] ^ lfsr[7:0];
            step("R5 R6 R8 R10 random");
        end
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule